// File: doc/BRIEF.md
# Vector Table Byte Lookup Unit

This block looks up eight bytes at a time in a table made of one to four consecutive 128-bit vector registers. It holds a 32-entry register file of 128-bit registers, which is loaded through a plain write port. A lookup request carries a 64-bit word of eight byte indices, the number of the first table register, a 2-bit table length and a 64-bit starting result. Each byte of the returned word is either a byte taken from the table or, when its index lies past the end of the table, the matching byte of the starting result.

With an all-zero starting result the block gives the zero-filling form of the lookup. With the old destination bytes as the starting result it gives the merging form. The table is treated as the selected registers laid end to end, and it wraps from the last register of the file back to register 0. The result is registered and comes back one cycle after the request, with a one-cycle valid pulse.

Top module: `vtbl_lookup_unit`

## Requirements
- R1: While reset is asserted, and until the first request after reset, `rsp_valid` is 0 and `rsp_data` is all zeros.
- R2: A request sampled at a rising edge (`req_valid` = 1) gives `rsp_valid` = 1 in the following cycle. A cycle without a request gives `rsp_valid` = 0 in the next cycle, so back-to-back requests give back-to-back results.
- R3: Result byte i (bits 8i+7..8i) depends only on index byte i (bits 8i+7..8i of `req_idx`) and on the matching byte of `req_init`.
- R4: `req_len` holds the number of table registers minus one (0 means 1 register, 3 means 4 registers). An index is in range only when it is less than 16 × (`req_len` + 1).
- R5: An out-of-range index returns the matching byte of `req_init` unchanged. Indices of 64 and above are always out of range.
- R6: The file is read as 64 halves of 64 bits. Half 2r is bits 63..0 of register r and half 2r+1 is bits 127..64. An in-range index reads half (2 × `req_start` + index[7:3]) mod 64.
- R7: Within the selected half, index[2:0] picks the byte, and byte 0 is bits 7..0.
- R8: A table that runs past register 31 continues at register 0.
- R9: A write and a lookup in the same cycle are allowed. The lookup returns the register contents from before the write, and the next lookup sees the new contents.
- R10: In a cycle with no request, `rsp_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register-file write enable |
| wr_addr | input | 5 | Register number to write |
| wr_data | input | 128 | Data to write |
| req_valid | input | 1 | Lookup request |
| req_idx | input | 64 | Eight byte indices, lane i in bits 8i+7..8i |
| req_start | input | 5 | First table register |
| req_len | input | 2 | Table length minus one |
| req_init | input | 64 | Starting result; supplies the bytes for out-of-range indices |
| rsp_valid | output | 1 | Result valid, one cycle per request |
| rsp_data | output | 64 | Lookup result |

## Verification
The assertions check the response handshake on every cycle: every request gets a valid pulse one cycle later, there is no pulse without a request, and the data holds between requests. They also check that a request whose indices are all 64 or above returns its starting result exactly. Which register and byte an in-range index reaches, the exact range limit for each table length, wrapping past register 31, and old data being returned when a write and a lookup fall in the same cycle can only be shown by the bench's scenarios, which compare against a register-level model of the table.

// File: rtl/vtbl_pkg.sv
package vtbl_pkg;
  localparam int unsigned VT_NUM_REGS   = 32;
  localparam int unsigned VT_REG_W      = 128;
  localparam int unsigned VT_LANES      = 8;
  localparam int unsigned VT_BYTE_W     = 8;
  localparam int unsigned VT_LEN_W      = 2;
  localparam int unsigned VT_HALF_W     = VT_LANES * VT_BYTE_W;
  localparam int unsigned VT_REG_AW     = $clog2(VT_NUM_REGS);
  localparam int unsigned VT_HALVES     = VT_NUM_REGS * VT_REG_W / VT_HALF_W;
  localparam int unsigned VT_HALF_AW    = $clog2(VT_HALVES);
  localparam int unsigned VT_REG_BYTES  = VT_REG_W / VT_BYTE_W;
endpackage

// File: rtl/vtbl_regfile.sv
module vtbl_regfile #(
  parameter int unsigned NUM_REGS = vtbl_pkg::VT_NUM_REGS,
  parameter int unsigned REG_W    = vtbl_pkg::VT_REG_W,
  parameter int unsigned HALF_W   = vtbl_pkg::VT_HALF_W,
  localparam int unsigned REG_AW  = $clog2(NUM_REGS),
  localparam int unsigned HPR     = REG_W / HALF_W,
  localparam int unsigned HALVES  = NUM_REGS * HPR
) (
  input  logic                          clk,
  input  logic                          wr_en,
  input  logic [REG_AW-1:0]             wr_addr,
  input  logic [REG_W-1:0]              wr_data,
  output logic [HALVES-1:0][HALF_W-1:0] half_q
);

  logic [REG_W-1:0]    mem_q [NUM_REGS];
  logic [NUM_REGS-1:0] row_we;

  // Write decode: one clock enable per register
  always_comb begin
    row_we = '0;
    if (wr_en) row_we[wr_addr] = 1'b1;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (row_we[r]) mem_q[r] <= wr_data;
    end
    // Expose each register as HPR halves, lower half first
    for (genvar h = 0; h < HPR; h++) begin : g_half
      assign half_q[r*HPR + h] = mem_q[r][h*HALF_W +: HALF_W];
    end
  end

endmodule

// File: rtl/vtbl_lane.sv
module vtbl_lane #(
  parameter int unsigned HALVES    = vtbl_pkg::VT_HALVES,
  parameter int unsigned HALF_W    = vtbl_pkg::VT_HALF_W,
  parameter int unsigned BYTE_W    = vtbl_pkg::VT_BYTE_W,
  parameter int unsigned REG_AW    = vtbl_pkg::VT_REG_AW,
  parameter int unsigned LEN_W     = vtbl_pkg::VT_LEN_W,
  parameter int unsigned REG_BYTES = vtbl_pkg::VT_REG_BYTES,
  localparam int unsigned HALF_AW  = $clog2(HALVES),
  localparam int unsigned BSEL_W   = $clog2(HALF_W / BYTE_W),
  localparam int unsigned HPR      = REG_BYTES * BYTE_W / HALF_W
) (
  input  logic [BYTE_W-1:0]             idx,
  input  logic [REG_AW-1:0]             start,
  input  logic [LEN_W-1:0]              len,
  input  logic [BYTE_W-1:0]             init_byte,
  input  logic [HALVES-1:0][HALF_W-1:0] half_q,
  output logic [BYTE_W-1:0]             lane_byte
);

  logic [BYTE_W:0]     limit;
  logic                in_range;
  logic [HALF_AW-1:0]  half_sel;
  logic [BSEL_W-1:0]   byte_sel;
  logic [HALF_W-1:0]   sel_half;
  logic [BYTE_W-1:0]   picked;

  always_comb begin
    // Table length in bytes; one bit wider than an index
    limit    = (BYTE_W+1)'((32'(len) + 32'd1) * REG_BYTES);
    in_range = {1'b0, idx} < limit;
    // Truncation to HALF_AW bits gives the wrap past the last register
    half_sel = HALF_AW'(32'(start) * HPR + 32'(idx >> BSEL_W));
    byte_sel = idx[BSEL_W-1:0];
    sel_half = half_q[half_sel];
    picked   = sel_half[byte_sel*BYTE_W +: BYTE_W];
    lane_byte = in_range ? picked : init_byte;
  end

endmodule

// File: rtl/vtbl_lookup_unit.sv
module vtbl_lookup_unit #(
  parameter int unsigned NUM_REGS = vtbl_pkg::VT_NUM_REGS,
  parameter int unsigned REG_W    = vtbl_pkg::VT_REG_W,
  parameter int unsigned LANES    = vtbl_pkg::VT_LANES,
  parameter int unsigned BYTE_W   = vtbl_pkg::VT_BYTE_W,
  parameter int unsigned LEN_W    = vtbl_pkg::VT_LEN_W,
  localparam int unsigned REG_AW  = $clog2(NUM_REGS),
  localparam int unsigned WORD_W  = LANES * BYTE_W,
  localparam int unsigned HALVES  = NUM_REGS * REG_W / WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              req_valid,
  input  logic [WORD_W-1:0] req_idx,
  input  logic [REG_AW-1:0] req_start,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [WORD_W-1:0] req_init,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data
);

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  logic [HALVES-1:0][WORD_W-1:0] half_q;

  vtbl_regfile #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .HALF_W   (WORD_W)
  ) u_regfile (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .half_q  (half_q)
  );

  logic [WORD_W-1:0] lookup_data;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    vtbl_lane #(
      .HALVES    (HALVES),
      .HALF_W    (WORD_W),
      .BYTE_W    (BYTE_W),
      .REG_AW    (REG_AW),
      .LEN_W     (LEN_W),
      .REG_BYTES (REG_W / BYTE_W)
    ) u_lane (
      .idx       (req_idx[i*BYTE_W +: BYTE_W]),
      .start     (req_start),
      .len       (req_len),
      .init_byte (req_init[i*BYTE_W +: BYTE_W]),
      .half_q    (half_q),
      .lane_byte (lookup_data[i*BYTE_W +: BYTE_W])
    );
  end

  // Next state
  logic              rsp_valid_d, rsp_valid_q;
  logic [WORD_W-1:0] rsp_data_d,  rsp_data_q;

  always_comb begin
    rsp_valid_d = req_valid;
    rsp_data_d  = rsp_data_q;
    if (req_valid) rsp_data_d = lookup_data;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_data_q  <= rsp_data_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/vtbl_lookup_checker.sv
module vtbl_lookup_checker #(
  parameter int unsigned LANES  = vtbl_pkg::VT_LANES,
  parameter int unsigned BYTE_W = vtbl_pkg::VT_BYTE_W,
  localparam int unsigned WORD_W = LANES * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [WORD_W-1:0] req_idx,
  input logic [WORD_W-1:0] req_init,
  input logic              rsp_valid,
  input logic [WORD_W-1:0] rsp_data
);

  // True when every index has one of its two top bits set (64 or more)
  function automatic logic all_far(input logic [WORD_W-1:0] w);
    logic f;
    f = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if (w[i*BYTE_W + BYTE_W - 1 -: 2] == 2'b00) f = 1'b0;
    end
    return f;
  endfunction

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2

  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_data)); // R10

  AST_FAR_KEEPS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && all_far(req_idx)) |=> (rsp_data == $past(req_init))); // R5

  AST_VALID_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(rsp_valid)); // R1

endmodule

bind vtbl_lookup_unit vtbl_lookup_checker #(
  .LANES  (LANES),
  .BYTE_W (BYTE_W)
) u_vtbl_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .req_valid (req_valid),
  .req_idx   (req_idx),
  .req_init  (req_init),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data)
);

// File: tb/tb_vtbl_lookup_unit.sv
`timescale 1ns/1ps
module tb_vtbl_lookup_unit;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [4:0]   wr_addr;
  logic [127:0] wr_data;
  logic         req_valid;
  logic [63:0]  req_idx;
  logic [4:0]   req_start;
  logic [1:0]   req_len;
  logic [63:0]  req_init;
  logic         rsp_valid;
  logic [63:0]  rsp_data;

  always #2 clk = ~clk;   // 250 MHz

  vtbl_lookup_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_valid(req_valid), .req_idx(req_idx), .req_start(req_start), .req_len(req_len),
    .req_init(req_init), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [127:0] shadow [32];

  typedef struct packed {
    logic [63:0] idx;
    logic [4:0]  start;
    logic [1:0]  len;
    logic [63:0] init;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{64'h0706050403020100, 5'd0,  2'd0, 64'h0},                  // R7 byte order
    '{64'h0F0E0D0C0B0A0908, 5'd5,  2'd0, 64'h0},                  // R6 upper half
    '{64'h3F30201F10000908, 5'd2,  2'd3, 64'h0},                  // R4 four registers
    '{64'h4010FF0512800F01, 5'd1,  2'd0, 64'h1122334455667788},   // R5 merge form
    '{64'h3F2F1F0F30201000, 5'd30, 2'd3, 64'h0},                  // R8 wrap
    '{64'h1F1E11100F0E0100, 5'd31, 2'd1, 64'h0},                  // R8 wrap from 31
    '{64'h20201F1F20001F00, 5'd9,  2'd1, 64'hAAAAAAAAAAAAAAAA},   // R4 two-register limit
    '{64'h0001020304050607, 5'd12, 2'd2, 64'h5555555555555555}    // R3 lanes reversed
  };

  function automatic logic [7:0] pat(int r, int b);
    return 8'(r*37 + b*11 + 5);
  endfunction

  // Register-level model: table register = start + idx/16, byte = idx%16
  function automatic logic [63:0] ref_lookup(logic [63:0] idx, logic [4:0] start,
                                             logic [1:0] len, logic [63:0] init);
    logic [63:0] r;
    r = init;
    for (int i = 0; i < 8; i++) begin
      int v;
      int rn;
      v = int'(idx[8*i +: 8]);
      if (v < 16 * (int'(len) + 1)) begin
        rn = (int'(start) + v / 16) % 32;
        r[8*i +: 8] = shadow[rn][8*(v % 16) +: 8];
      end
    end
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(int r, logic [127:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(r); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    shadow[r] = d;
  endtask

  // One request; checks valid pulse, data, and hold in the idle cycle after
  task automatic do_req(string tag, logic [63:0] idx, logic [4:0] start,
                        logic [1:0] len, logic [63:0] init);
    logic [63:0] exp;
    exp = ref_lookup(idx, start, len, init);
    @(negedge clk);
    req_valid = 1'b1; req_idx = idx; req_start = start; req_len = len; req_init = init;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R2 valid"}, 64'(rsp_valid), 64'd1);
    check({tag, " data"}, rsp_data, exp);
    @(negedge clk);
    check({tag, " R2 pulse end"}, 64'(rsp_valid), 64'd0);
    check({tag, " R10 hold"}, rsp_data, exp);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    req_valid = 1'b0; req_idx = '0; req_start = '0; req_len = '0; req_init = '0;
    repeat (4) @(negedge clk);
    check("R1 reset valid", 64'(rsp_valid), 64'd0);
    check("R1 reset data", rsp_data, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", 64'(rsp_valid), 64'd0);

    for (int r = 0; r < 32; r++) begin
      logic [127:0] d;
      for (int b = 0; b < 16; b++) d[8*b +: 8] = pat(r, b);
      wr_reg(r, d);
    end

    // Table walk: R3 R4 R5 R6 R7 R8
    for (int k = 0; k < NVEC; k++) begin
      do_req($sformatf("R3/R6 vector %0d", k), VEC[k].idx, VEC[k].start, VEC[k].len, VEC[k].init);
    end

    // R4: exact limit for four registers (63 in, 64 out)
    do_req("R4 limit len3", 64'h403F403F403F403F, 5'd8, 2'd3, 64'h0123456789ABCDEF);
    // R4: one register, 15 in and 16 out
    do_req("R4 limit len0", 64'h0F100F100F100F10, 5'd20, 2'd0, 64'hFFFFFFFFFFFFFFFF);
    // R5: zero-filling form, all out of range
    do_req("R5 zero form", 64'hFF807F40C0A0E041, 5'd3, 2'd3, 64'h0);
    // R5: merge form, all out of range keeps old bytes
    do_req("R5 merge form", 64'hFF807F40C0A0E041, 5'd3, 2'd3, 64'hDEADBEEFCAFEF00D);
    // R8: start 29 length 4 spans registers 29,30,31,0
    do_req("R8 wrap 29", 64'h0030203F2F1F0F00, 5'd29, 2'd3, 64'h0);

    // R9: write register 3 and look it up in the same cycle
    begin
      logic [63:0]  exp_old;
      logic [127:0] nd;
      nd = ~shadow[3];
      exp_old = ref_lookup(64'h0F0E090807060100, 5'd3, 2'd0, 64'h0);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'd3; wr_data = nd;
      req_valid = 1'b1; req_idx = 64'h0F0E090807060100; req_start = 5'd3;
      req_len = 2'd0; req_init = 64'h0;
      @(negedge clk);
      wr_en = 1'b0; req_valid = 1'b0;
      check("R9 old contents", rsp_data, exp_old);
      shadow[3] = nd;
      do_req("R9 new contents", 64'h0F0E090807060100, 5'd3, 2'd0, 64'h0);
    end

    // R2: back-to-back requests
    begin
      logic [63:0] ea, eb;
      ea = ref_lookup(64'h0102030405060708, 5'd7, 2'd0, 64'h0);
      eb = ref_lookup(64'h1112131415161718, 5'd16, 2'd1, 64'h0);
      @(negedge clk);
      req_valid = 1'b1; req_idx = 64'h0102030405060708; req_start = 5'd7; req_len = 2'd0; req_init = 64'h0;
      @(negedge clk);
      check("R2 b2b first valid", 64'(rsp_valid), 64'd1);
      check("R2 b2b first data", rsp_data, ea);
      req_idx = 64'h1112131415161718; req_start = 5'd16; req_len = 2'd1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R2 b2b second valid", 64'(rsp_valid), 64'd1);
      check("R2 b2b second data", rsp_data, eb);
      @(negedge clk);
      check("R2 b2b end", 64'(rsp_valid), 64'd0);
    end

    // R10: idle inputs change, output holds
    begin
      logic [63:0] held;
      held = rsp_data;
      req_idx = 64'h0; req_init = 64'hFFFF0000FFFF0000;
      repeat (3) @(negedge clk);
      check("R10 idle hold", rsp_data, held);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule